// File: doc/BRIEF.md
# Packed Program Counter and Status Register

This block keeps the machine state of a small processor in one 32-bit word. The word holds the fetch address, six condition and interrupt-mask flags, and a two-bit processor mode. Because all three share one register, a subroutine call or an exception can save the whole state with a single read. A return restores the whole state with a single write. No separate status transfer is needed.

Around the register the block does the following:
- It presents a byte fetch address that is always word-aligned.
- It advances that address by one word on each sequential step.
- It loads branch targets.
- It accepts condition flags from an ALU.
- It switches mode and masks interrupts on exception entry.

The addressable space is 64 MiB. In compatibility mode on a wider bus, a branch target beyond the last executable word (0x3FFFFFC) is refused. The refusal raises a fault flag.

Packed word layout, from bit 31 down:
- Bit 31: N.
- Bit 30: Z.
- Bit 29: C.
- Bit 28: V.
- Bit 27: IRQ disable (I).
- Bit 26: FIQ disable (F).
- Bits 25:2: word address.
- Bits 1:0: mode. The encodings are user = 00, FIQ = 01, IRQ = 10 and supervisor = 11.

Top module: `pcsr_unit`

## Requirements
- R1: After reset the packed word reads 0x0C000003. The address field is zero, I and F are set, the mode is supervisor (11) and the fault flag is low.
- R2: A step with no branch, exception or restore adds 4 to the low 26 bits, wrapping 0x3FFFFFC to 0. Bits 31:26 and 1:0 are unchanged.
- R3: An accepted branch replaces bits 25:2 with target bits 25:2. Target bits 1:0 are ignored.
- R4: A flag write copies alu_flags_i[3:0] into bits 31:28 (N, Z, C, V). I, F, mode and address are left alone.
- R5: Exception entry does four things in the next word:
  - the mode becomes exc_mode_i;
  - I is set;
  - F is set if the mode is FIQ (01), and is kept otherwise;
  - bits 25:2 take exc_vector_i[25:2].
  During the entry cycle, word_o still shows the pre-entry word.
- R6: A restore in a mode other than user loads all 32 bits of restore_word_i in one cycle.
- R7: A restore in user mode (00) loads only bits 31:28 and 25:2. Bits 27:26 and 1:0 keep their values.
- R8: With compat_i high, a branch whose target has any of bits 31:26 set is refused. The address is held and fault_o rises. With compat_i low, those target bits are dropped and the branch is taken.
- R9: Priority, from highest to lowest, is restore, exception, branch, step. A flag write is ignored in a cycle with a restore or an exception.
- R10: fault_o clears on the next accepted branch, restore or exception.
- R11: fetch_addr_o is bits 25:2 of the word, shifted left by 2, with zeros in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Advance by one word |
| branch_i | input | 1 | Load branch target |
| branch_target_i | input | 32 | Branch target byte address |
| compat_i | input | 1 | Enforce the 64 MiB fetch limit on branches |
| flags_we_i | input | 1 | Write N, Z, C, V from the ALU |
| alu_flags_i | input | 4 | N, Z, C, V from bit 3 down |
| exc_i | input | 1 | Exception entry |
| exc_mode_i | input | 2 | Mode entered on exception |
| exc_vector_i | input | 26 | Handler byte address |
| restore_i | input | 1 | Restore the packed word |
| restore_word_i | input | 32 | Packed word to restore |
| fetch_addr_o | output | 32 | Word-aligned fetch address |
| word_o | output | 32 | Current packed word, used for saves |
| fault_o | output | 1 | Fetch range fault |

## Verification
The assertions take the control strobes to be known values after reset. They do not assume the strobes are one-hot: each property names the higher-priority strobes it excludes. So the stimulus may raise restore, exception, branch and step together. The priority checks rely on exactly that. The bench keeps exc_mode_i to the four defined encodings. It drives every input at the falling edge, so each strobe is seen at exactly one rising edge.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
    parameter int unsigned PC_W   = 26;
    parameter int unsigned FLAG_W = 6;
    parameter int unsigned MODE_W = 2;
    parameter int unsigned COND_W = 4;
    localparam int unsigned WORD_W = FLAG_W + PC_W;
    localparam int unsigned ADDR_W = PC_W - MODE_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 2'b00,
        MODE_FIQ = 2'b01,
        MODE_IRQ = 2'b10,
        MODE_SVC = 2'b11
    } cpu_mode_e;

    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic              irq_off;
        logic              fiq_off;
    } flags_t;

    typedef struct packed {
        flags_t            flags;
        logic [ADDR_W-1:0] addr;
        cpu_mode_e         mode;
    } pcsr_word_t;

    typedef struct packed {
        pcsr_word_t word;
        logic       fault;
    } pcsr_state_t;
endpackage

// File: rtl/pcsr_range_guard.sv
module pcsr_range_guard
    import pcsr_pkg::*;
#(
    parameter int unsigned BUS_W = 32
) (
    input  logic                  branch_i,
    input  logic                  compat_i,
    input  logic [BUS_W-PC_W-1:0] high_bits_i,
    output logic                  take_o,
    output logic                  refuse_o
);
    logic beyond;

    generate
        if (BUS_W > PC_W) begin : g_wide
            assign beyond = |high_bits_i;
        end else begin : g_narrow
            assign beyond = 1'b0;
        end
    endgenerate

    assign refuse_o = branch_i & compat_i & beyond;
    assign take_o   = branch_i & ~refuse_o;
endmodule

// File: rtl/pcsr_seq_adv.sv
module pcsr_seq_adv
    import pcsr_pkg::*;
(
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [ADDR_W-1:0] target_addr_i,
    input  logic              step_i,
    input  logic              branch_req_i,
    input  logic              branch_take_i,
    output logic [ADDR_W-1:0] next_addr_o
);
    localparam logic [ADDR_W-1:0] ONE_WORD = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        next_addr_o = cur_addr_i;
        if (branch_take_i) begin
            next_addr_o = target_addr_i;
        end else if (!branch_req_i && step_i) begin
            next_addr_o = cur_addr_i + ONE_WORD;
        end
    end
endmodule

// File: rtl/pcsr_restore_filter.sv
module pcsr_restore_filter
    import pcsr_pkg::*;
(
    input  pcsr_word_t cur_i,
    input  pcsr_word_t saved_i,
    output pcsr_word_t out_o
);
    always_comb begin
        out_o = saved_i;
        if (cur_i.mode == MODE_USR) begin
            out_o.flags.irq_off = cur_i.flags.irq_off;
            out_o.flags.fiq_off = cur_i.flags.fiq_off;
            out_o.mode          = cur_i.mode;
        end
    end
endmodule

// File: rtl/pcsr_unit.sv
module pcsr_unit
    import pcsr_pkg::*;
#(
    parameter int unsigned BUS_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              branch_i,
    input  logic [BUS_W-1:0]  branch_target_i,
    input  logic              compat_i,
    input  logic              flags_we_i,
    input  logic [COND_W-1:0] alu_flags_i,
    input  logic              exc_i,
    input  logic [MODE_W-1:0] exc_mode_i,
    input  logic [PC_W-1:0]   exc_vector_i,
    input  logic              restore_i,
    input  logic [WORD_W-1:0] restore_word_i,
    output logic [BUS_W-1:0]  fetch_addr_o,
    output logic [WORD_W-1:0] word_o,
    output logic              fault_o
);
    localparam pcsr_state_t RESET_ST = '{
        word:  '{flags: '{cond: '0, irq_off: 1'b1, fiq_off: 1'b1},
                 addr:  '0,
                 mode:  MODE_SVC},
        fault: 1'b0
    };

    pcsr_state_t       state_d, state_q;
    logic              br_take, br_refuse;
    logic [ADDR_W-1:0] seq_addr;
    pcsr_word_t        restored;
    cpu_mode_e         new_mode;
    logic              unused_low;

    assign unused_low = ^{branch_target_i[MODE_W-1:0], exc_vector_i[MODE_W-1:0]};
    assign new_mode   = cpu_mode_e'(exc_mode_i);

    pcsr_range_guard #(.BUS_W(BUS_W)) guard_i (
        .branch_i    (branch_i),
        .compat_i    (compat_i),
        .high_bits_i (branch_target_i[BUS_W-1:PC_W]),
        .take_o      (br_take),
        .refuse_o    (br_refuse)
    );

    pcsr_seq_adv adv_i (
        .cur_addr_i    (state_q.word.addr),
        .target_addr_i (branch_target_i[PC_W-1:MODE_W]),
        .step_i        (step_i),
        .branch_req_i  (branch_i),
        .branch_take_i (br_take),
        .next_addr_o   (seq_addr)
    );

    pcsr_restore_filter filt_i (
        .cur_i   (state_q.word),
        .saved_i (pcsr_word_t'(restore_word_i)),
        .out_o   (restored)
    );

    always_comb begin
        state_d = state_q;
        if (restore_i) begin
            state_d.word  = restored;
            state_d.fault = 1'b0;
        end else if (exc_i) begin
            state_d.word.mode          = new_mode;
            state_d.word.flags.irq_off = 1'b1;
            if (new_mode == MODE_FIQ) begin
                state_d.word.flags.fiq_off = 1'b1;
            end
            state_d.word.addr = exc_vector_i[PC_W-1:MODE_W];
            state_d.fault     = 1'b0;
        end else begin
            state_d.word.addr = seq_addr;
            if (flags_we_i) begin
                state_d.word.flags.cond = alu_flags_i;
            end
            if (branch_i) begin
                state_d.fault = br_refuse;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= RESET_ST;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o       = state_q.word;
    assign fault_o      = state_q.fault;
    assign fetch_addr_o = {{(BUS_W-PC_W){1'b0}}, state_q.word.addr, {MODE_W{1'b0}}};
endmodule

// File: rtl/pcsr_unit_chk.sv
module pcsr_unit_chk
    import pcsr_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              step_i,
    input logic              branch_i,
    input logic [31:0]       branch_target_i,
    input logic              compat_i,
    input logic              flags_we_i,
    input logic              exc_i,
    input logic [MODE_W-1:0] exc_mode_i,
    input logic              restore_i,
    input logic [31:0]       fetch_addr_o,
    input logic [31:0]       word_o,
    input logic              fault_o
);
    // R2: a plain step moves one word ahead and keeps the flags and mode
    assert_step_adds_four_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !branch_i && !exc_i && !restore_i && !flags_we_i) |=>
        (word_o[25:2] == $past(word_o[25:2]) + 24'd1) &&
        (word_o[31:26] == $past(word_o[31:26])) && (word_o[1:0] == $past(word_o[1:0])));

    // R5: after exception entry, IRQs are masked and the requested mode is active
    assert_exc_masks_irq_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_i && !restore_i) |=> (word_o[27] && (word_o[1:0] == $past(exc_mode_i))));

    // R7: a user-mode restore cannot touch the mask bits or the mode
    assert_user_restore_keeps_ctrl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (restore_i && word_o[1:0] == 2'b00) |=>
        (word_o[27:26] == $past(word_o[27:26])) && (word_o[1:0] == 2'b00));

    // R8: a refused branch raises the fault and holds the address
    assert_range_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (branch_i && compat_i && !exc_i && !restore_i && (|branch_target_i[31:26])) |=>
        (fault_o && $stable(word_o[25:2])));

    // R9: flag writes are ignored while an exception is being entered
    assert_exc_blocks_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_i && !restore_i) |=> (word_o[31:28] == $past(word_o[31:28])));

    // R11: the fetch address follows the word and stays aligned in the 64 MiB window
    assert_fetch_aligned_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_addr_o[1:0] == 2'b00) && (fetch_addr_o[31:26] == 6'd0) &&
        (fetch_addr_o[25:2] == word_o[25:2]));
endmodule

bind pcsr_unit pcsr_unit_chk chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .step_i          (step_i),
    .branch_i        (branch_i),
    .branch_target_i (branch_target_i),
    .compat_i        (compat_i),
    .flags_we_i      (flags_we_i),
    .exc_i           (exc_i),
    .exc_mode_i      (exc_mode_i),
    .restore_i       (restore_i),
    .fetch_addr_o    (fetch_addr_o),
    .word_o          (word_o),
    .fault_o         (fault_o)
);

// File: tb/pcsr_unit_tb_top.sv
`timescale 1ns/1ps
module pcsr_unit_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        step_i = 1'b0;
    logic        branch_i = 1'b0;
    logic [31:0] branch_target_i = '0;
    logic        compat_i = 1'b0;
    logic        flags_we_i = 1'b0;
    logic [3:0]  alu_flags_i = '0;
    logic        exc_i = 1'b0;
    logic [1:0]  exc_mode_i = '0;
    logic [25:0] exc_vector_i = '0;
    logic        restore_i = 1'b0;
    logic [31:0] restore_word_i = '0;
    logic [31:0] fetch_addr_o;
    logic [31:0] word_o;
    logic        fault_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] m_word;
    logic        m_fault;
    logic [31:0] q_word[$];
    logic        q_fault[$];
    string       q_tag[$];

    always #2 clk_i = ~clk_i;

    pcsr_unit dut_i (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic br, input logic [31:0] tgt, input logic cm,
                         input logic fw, input logic [3:0] fl, input logic ex, input logic [1:0] em,
                         input logic [25:0] vec, input logic rs, input logic [31:0] rw,
                         input string tag);
        logic refuse;
        @(negedge clk_i);
        step_i = st; branch_i = br; branch_target_i = tgt; compat_i = cm;
        flags_we_i = fw; alu_flags_i = fl; exc_i = ex; exc_mode_i = em;
        exc_vector_i = vec; restore_i = rs; restore_word_i = rw;
        if (ex) check({"R5 save word in entry cycle ", tag}, word_o, m_word);
        refuse = br && cm && (tgt[31:26] != 6'd0);
        if (rs) begin
            if (m_word[1:0] == 2'b00)
                m_word = {rw[31:28], m_word[27:26], rw[25:2], m_word[1:0]};
            else
                m_word = rw;
            m_fault = 1'b0;
        end else if (ex) begin
            m_word[1:0] = em;
            m_word[27] = 1'b1;
            if (em == 2'b01) m_word[26] = 1'b1;
            m_word[25:2] = vec[25:2];
            m_fault = 1'b0;
        end else begin
            if (br && !refuse) m_word[25:2] = tgt[25:2];
            else if (!br && st) m_word[25:0] = m_word[25:0] + 26'd4;
            if (fw) m_word[31:28] = fl;
            if (br) m_fault = refuse;
        end
        q_word.push_back(m_word);
        q_fault.push_back(m_fault);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk_i);
            #1;
            if (q_word.size() > 0) begin
                logic [31:0] w;
                logic        f;
                string       t;
                w = q_word.pop_front();
                f = q_fault.pop_front();
                t = q_tag.pop_front();
                check({t, " word"}, word_o, w);
                check({t, " fault"}, {31'd0, fault_o}, {31'd0, f});
                check({t, " R11 fetch"}, fetch_addr_o, {6'd0, w[25:2], 2'b00});
            end
        end
    end

    initial begin : watchdog
        #40000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        m_word = 32'h0C00_0003;
        m_fault = 1'b0;
        check("R1 reset word", word_o, 32'h0C00_0003);
        check("R1 reset fault", {31'd0, fault_o}, 32'd0);
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 step a");
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 step b");
        drive(1, 0, 0, 0, 1, 4'b1010, 0, 0, 0, 0, 0, "R4 flags with step");
        drive(0, 0, 0, 0, 1, 4'b0101, 0, 0, 0, 0, 0, "R4 flags alone");
        drive(1, 1, 32'h0000_1237, 0, 0, 0, 0, 0, 0, 0, 0, "R3 branch low bits ignored");
        drive(0, 1, 32'h03FF_FFFC, 0, 0, 0, 0, 0, 0, 0, 0, "R3 branch top word");
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 wrap to zero");
        drive(1, 1, 32'h0400_0000, 1, 0, 0, 0, 0, 0, 0, 0, "R8 compat refuse");
        drive(1, 1, 32'h0000_0040, 0, 0, 0, 0, 0, 0, 0, 0, "R10 branch clears fault");
        drive(0, 1, 32'hFC00_0010, 0, 0, 0, 0, 0, 0, 0, 0, "R8 no compat drops high bits");
        drive(1, 1, 32'h8000_0000, 1, 0, 0, 0, 0, 0, 0, 0, "R8 compat refuse b");
        drive(1, 1, 32'h0000_0100, 1, 1, 4'b1111, 1, 2'b10, 26'h18, 0, 0, "R9 R10 irq entry wins");
        drive(0, 0, 0, 0, 0, 0, 1, 2'b01, 26'h1C, 0, 0, "R5 fiq entry");
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hA000_1235, "R6 privileged restore");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h5000_0100, "R6 restore into user");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hFC00_0403, "R7 user restore masked");
        drive(0, 0, 0, 0, 0, 0, 1, 2'b11, 26'h08, 0, 0, "R5 svc entry from user");
        drive(0, 1, 32'h0400_0000, 1, 0, 0, 0, 0, 0, 0, 0, "R8 compat refuse c");
        drive(1, 1, 32'h0000_0200, 0, 1, 4'b0011, 1, 2'b10, 26'h18, 1, 32'h3000_0802,
              "R9 R10 restore wins");
        drive(1, 0, 0, 0, 1, 4'b1100, 0, 0, 0, 0, 0, "R4 R2 flags in irq mode");
        idle();
        idle();
        @(negedge clk_i);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule